// File: doc/BRIEF.md
# Weighted and Strict-Priority Output Queue Scheduler

This block decides which queue of a single output port may send its next packet. The port owns a contiguous group of queues. Each queue carries a priority code that software loads through a simple write port. A weighted code expands into an eight-bit round-enable mask whose set bits are spread across the rounds, so that heavier queues get proportionally more turns without their packets clustering. A strict code makes the queue part of a strict group that must start at the first queue of the port and have no gaps. Any non-empty strict queue beats every weighted queue, and a lower index wins inside the strict group.

Weighted queues are served by a scan that moves in ascending index order from the queue after the last weighted grant. A three-bit round counter selects which mask bit applies, and the round advances each time the scan passes the last queue of the port. A grant is held until the consumer signals packet completion, and the next decision comes one cycle after the grant drops. Priorities may be rewritten while traffic flows. Writes that would break the strict-group shape are refused, and they set a sticky error flag.

Top module: `wsp_queue_sched`

## Requirements
- R1: After a synchronous active-high reset, no queue is eligible: `gnt_valid` stays 0 even with every request high, and `cfg_err` is 0.
- R2: Weighted codes 0..8 on `cfg_prio` map to masks 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7F, 8→0xFF, where bit r enables the queue in round r. Over eight rounds of constant requests, a code-8 queue gets eight grants, a code-1 queue gets one, a code-4 queue gets four, and a code-0 queue gets none.
- R3: Code 9 makes a queue strict. The write is accepted only at index 0 or when the queue one index below is already strict. Rewriting a strict queue to a non-strict code is refused while the queue one index above is strict. A refused write leaves the queue's entry unchanged and sets `cfg_err`.
- R4: When any requesting strict queue exists, the grant goes to the lowest-indexed one, ahead of all weighted queues.
- R5: Weighted grants follow ascending index order, starting after the last weighted grant. Eligibility uses mask bit `round`, where the round counter starts at 0 and wraps after 7. The round advances by one when the scan passes the last queue of the port, either by granting it or by finding no eligible queue up to it.
- R6: The lowest index written with `cfg_tail`=1 is the last queue of the port, and higher queues are never granted. When no tail flag is set, all queues belong to the port.
- R7: Codes 10..15 are accepted as weighted with mask 0xFF, and they set `cfg_err`.
- R8: `gnt_valid` and `gnt_idx` hold while `pkt_done` is low. `gnt_valid` falls in the cycle after `pkt_done` is sampled high, and no new grant appears in that same cycle.
- R9: `cfg_err` stays 1 until reset once it has been set.
- R10: A priority rewritten while the unit runs changes the grants that follow, without a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | $clog2(NUM_Q) | Queue index being written |
| cfg_prio | input | 4 | Priority code 0..15 |
| cfg_tail | input | 1 | Marks the written queue as a port tail candidate |
| cfg_err | output | 1 | Sticky configuration error flag |
| req | input | NUM_Q | Per-queue non-empty indication |
| gnt_valid | output | 1 | A grant is being offered |
| gnt_idx | output | $clog2(NUM_Q) | Granted queue index |
| pkt_done | input | 1 | Consumer finished the granted packet |

## Verification
The hardest situations to reach are the refused writes, because they change nothing visible except the error flag. The stimulus first builds a legal two-queue strict group. It then tries to extend the group with a gap and to clear its head, and afterwards shows through the grants that the head queue still wins. Round state carries over from one traffic phase to the next, so the bench keeps its own round and scan position across phases. This lets wrap-around and partially spent rounds be checked after reprogramming and after tail removal.

// File: rtl/wsp_sched_pkg.sv
package wsp_sched_pkg;
    localparam int PRIO_W  = 4;
    localparam int MASK_W  = 8;
    localparam int ROUND_W = $clog2(MASK_W);
    localparam logic [PRIO_W-1:0] STRICT_CODE = 4'd9;

    // Spread enable pattern for each weight code
    function automatic logic [MASK_W-1:0] prio_mask(input logic [PRIO_W-1:0] code);
        logic [MASK_W-1:0] m;
        case (code)
            4'd0:    m = 8'h00;
            4'd1:    m = 8'h01;
            4'd2:    m = 8'h11;
            4'd3:    m = 8'h49;
            4'd4:    m = 8'h55;
            4'd5:    m = 8'h57;
            4'd6:    m = 8'h77;
            4'd7:    m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/wsp_cfg_table.sv
module wsp_cfg_table
    import wsp_sched_pkg::*;
#(
    parameter int NUM_Q = 8,
    localparam int QW = $clog2(NUM_Q)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [QW-1:0]                  idx,
    input  logic [PRIO_W-1:0]              prio,
    input  logic                           tail_in,
    output logic [NUM_Q-1:0][MASK_W-1:0]   mask_o,
    output logic [NUM_Q-1:0]               strict_o,
    output logic [QW-1:0]                  tail_idx_o,
    output logic                           err_o
);
    localparam logic [NUM_Q-1:0] ONE_Q = 1;

    typedef struct packed {
        logic [NUM_Q-1:0][MASK_W-1:0] mask;
        logic [NUM_Q-1:0]             strict;
        logic [NUM_Q-1:0]             tail;
        logic                         err;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [QW-1:0] idx_dn, idx_up;
    logic prev_strict, next_strict, is_strict_code, bad_code, reject;

    always_comb begin
        idx_dn         = idx - 1'b1;
        idx_up         = idx + 1'b1;
        prev_strict    = (idx == '0) ? 1'b1 : tbl_q.strict[idx_dn];
        next_strict    = (idx == QW'(NUM_Q - 1)) ? 1'b0 : tbl_q.strict[idx_up];
        is_strict_code = (prio == STRICT_CODE);
        bad_code       = (prio > STRICT_CODE);
        reject         = (is_strict_code && !prev_strict) ||
                         (!is_strict_code && tbl_q.strict[idx] && next_strict);
        tbl_d = tbl_q;
        if (we) begin
            if (reject) begin
                tbl_d.err = 1'b1;
            end else begin
                tbl_d.mask[idx]   = prio_mask(prio);
                tbl_d.strict[idx] = is_strict_code;
                tbl_d.tail[idx]   = tail_in;
                tbl_d.err         = tbl_q.err | bad_code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tbl_q <= '0;
        else     tbl_q <= tbl_d;
    end

    always_comb begin
        tail_idx_o = QW'(NUM_Q - 1);
        for (int i = NUM_Q - 1; i >= 0; i--) begin
            if (tbl_q.tail[i]) tail_idx_o = QW'(i);
        end
    end

    assign mask_o   = tbl_q.mask;
    assign strict_o = tbl_q.strict;
    assign err_o    = tbl_q.err;

    // R3: strict set is always a prefix starting at index 0
    a_r3_strict_prefix: assert property (@(posedge clk) disable iff (rst)
        ((tbl_q.strict + ONE_Q) & tbl_q.strict) == '0);

    // R9: error flag never clears outside reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
endmodule

// File: rtl/wsp_strict_pick.sv
module wsp_strict_pick #(
    parameter int NUM_Q = 8,
    localparam int QW = $clog2(NUM_Q)
) (
    input  logic [NUM_Q-1:0] req,
    input  logic [NUM_Q-1:0] strict,
    input  logic [QW-1:0]    tail_idx,
    output logic             found,
    output logic [QW-1:0]    win_idx
);
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        for (int i = NUM_Q - 1; i >= 0; i--) begin
            if (req[i] && strict[i] && (QW'(i) <= tail_idx)) begin
                found   = 1'b1;
                win_idx = QW'(i);
            end
        end
    end
endmodule

// File: rtl/wsp_wrr_pick.sv
module wsp_wrr_pick
    import wsp_sched_pkg::*;
#(
    parameter int NUM_Q = 8,
    localparam int QW = $clog2(NUM_Q)
) (
    input  logic [NUM_Q-1:0]             req,
    input  logic [NUM_Q-1:0]             strict,
    input  logic [NUM_Q-1:0][MASK_W-1:0] mask,
    input  logic [QW-1:0]                tail_idx,
    input  logic [ROUND_W-1:0]           round,
    input  logic [QW-1:0]                start,
    output logic                         hit,
    output logic [QW-1:0]                hit_idx,
    output logic                         any_w
);
    logic [NUM_Q-1:0] in_port, elig, live;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        assign in_port[g] = (QW'(g) <= tail_idx);
        assign live[g]    = req[g] && !strict[g] && in_port[g] && (mask[g] != '0);
        assign elig[g]    = live[g] && mask[g][round] && (QW'(g) >= start);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_Q - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit     = 1'b1;
                hit_idx = QW'(i);
            end
        end
        any_w = |live;
    end
endmodule

// File: rtl/wsp_queue_sched.sv
module wsp_queue_sched
    import wsp_sched_pkg::*;
#(
    parameter int NUM_Q = 8,
    localparam int QW = $clog2(NUM_Q)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [QW-1:0]     cfg_idx,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              cfg_tail,
    output logic              cfg_err,
    input  logic [NUM_Q-1:0]  req,
    output logic              gnt_valid,
    output logic [QW-1:0]     gnt_idx,
    input  logic              pkt_done
);
    typedef struct packed {
        logic               gv;
        logic [QW-1:0]      gidx;
        logic [QW-1:0]      start;
        logic [ROUND_W-1:0] round;
    } arb_t;

    arb_t st_d, st_q;

    logic [NUM_Q-1:0][MASK_W-1:0] mask;
    logic [NUM_Q-1:0]             strict;
    logic [QW-1:0]                tail_idx;
    logic                         s_found, w_hit, any_w;
    logic [QW-1:0]                s_idx, w_idx;

    wsp_cfg_table #(.NUM_Q(NUM_Q)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .prio(cfg_prio),
        .tail_in(cfg_tail), .mask_o(mask), .strict_o(strict),
        .tail_idx_o(tail_idx), .err_o(cfg_err)
    );

    wsp_strict_pick #(.NUM_Q(NUM_Q)) u_strict (
        .req(req), .strict(strict), .tail_idx(tail_idx),
        .found(s_found), .win_idx(s_idx)
    );

    wsp_wrr_pick #(.NUM_Q(NUM_Q)) u_wrr (
        .req(req), .strict(strict), .mask(mask), .tail_idx(tail_idx),
        .round(st_q.round), .start(st_q.start),
        .hit(w_hit), .hit_idx(w_idx), .any_w(any_w)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.gv) begin
            if (pkt_done) st_d.gv = 1'b0;
        end else if (s_found) begin
            st_d.gv   = 1'b1;
            st_d.gidx = s_idx;
        end else if (w_hit) begin
            st_d.gv   = 1'b1;
            st_d.gidx = w_idx;
            if (w_idx == tail_idx) begin
                st_d.start = '0;
                st_d.round = st_q.round + 1'b1;
            end else begin
                st_d.start = w_idx + 1'b1;
            end
        end else if (any_w) begin
            st_d.start = '0;
            st_d.round = st_q.round + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign gnt_valid = st_q.gv;
    assign gnt_idx   = st_q.gidx;

    // R8: grant is frozen until the consumer finishes
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && !pkt_done) |=> (gnt_valid && $stable(gnt_idx)));

    // R8: completion drops the grant with a one-cycle gap
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && pkt_done) |=> !gnt_valid);

    // R4: a requesting strict queue takes the next grant
    a_r4_strict_first: assert property (@(posedge clk) disable iff (rst)
        (!gnt_valid && s_found) |=> (gnt_valid && gnt_idx == $past(s_idx)));

    // R5: round counter only ever steps by one
    a_r5_round_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.round) |-> (st_q.round == ROUND_W'($past(st_q.round) + 1'b1)));
endmodule

// File: tb/wsp_queue_sched_tb.sv
module wsp_queue_sched_tb;
    localparam int NQ = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [2:0] cfg_idx;
    logic [3:0] cfg_prio;
    logic       cfg_tail;
    logic       cfg_err;
    logic [7:0] req;
    logic       gnt_valid;
    logic [2:0] gnt_idx;
    logic       pkt_done;

    always #10 clk = ~clk;

    wsp_queue_sched #(.NUM_Q(NQ)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_prio(cfg_prio), .cfg_tail(cfg_tail), .cfg_err(cfg_err),
        .req(req), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .pkt_done(pkt_done)
    );

    int    n_cmp = 0, n_bad = 0;
    int    exp_q[$];
    string cur_tag = "";
    int    hold_cycles = 0;
    int    gcount[NQ];
    int    m_prio[NQ];
    bit    m_tail[NQ];
    int    m_start = 0, m_round = 0;
    bit    m_err = 0;
    bit    done_flag = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_mask(input int p);
        case (p)
            0: return 8'h00; 1: return 8'h01; 2: return 8'h11;
            3: return 8'h49; 4: return 8'h55; 5: return 8'h57;
            6: return 8'h77; 7: return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic int ref_tail();
        for (int i = 0; i < NQ; i++) if (m_tail[i]) return i;
        return NQ - 1;
    endfunction

    function automatic bit ref_weighted_ok(input logic [7:0] r, input int i, input int rd);
        logic [7:0] mk;
        mk = ref_mask(m_prio[i]);
        return r[i] && (m_prio[i] != 9) && mk[rd];
    endfunction

    function automatic int ref_next(input logic [7:0] r);
        int  t;
        bit  anyw;
        t = ref_tail();
        for (int i = 0; i <= t; i++) if (r[i] && m_prio[i] == 9) return i;
        anyw = 0;
        for (int i = 0; i <= t; i++)
            if (r[i] && m_prio[i] != 9 && ref_mask(m_prio[i]) != 0) anyw = 1;
        if (!anyw) return -1;
        for (int guard = 0; guard < 16; guard++) begin
            for (int i = m_start; i <= t; i++) begin
                if (ref_weighted_ok(r, i, m_round)) begin
                    if (i == t) begin
                        m_start = 0;
                        m_round = (m_round + 1) % 8;
                    end else begin
                        m_start = i + 1;
                    end
                    return i;
                end
            end
            m_start = 0;
            m_round = (m_round + 1) % 8;
        end
        return -1;
    endfunction

    task automatic cfg_write(input int idx, input int prio, input bit tl, input string tag);
        bit prev_s, next_s, rej;
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_prio = 4'(prio); cfg_tail = tl;
        @(negedge clk);
        cfg_we = 1'b0;
        prev_s = (idx == 0) ? 1'b1 : (m_prio[idx-1] == 9);
        next_s = (idx == NQ - 1) ? 1'b0 : (m_prio[idx+1] == 9);
        rej = ((prio == 9) && !prev_s) || ((prio != 9) && (m_prio[idx] == 9) && next_s);
        if (rej) m_err = 1'b1;
        else begin
            m_prio[idx] = prio;
            m_tail[idx] = tl;
            if (prio > 9) m_err = 1'b1;
        end
        check(cfg_err == m_err, tag, int'(cfg_err), int'(m_err));
    endtask

    // Driver: predicts n grants, applies the request pattern, then withdraws it
    task automatic run(input logic [7:0] r, input int n, input string tag);
        for (int k = 0; k < NQ; k++) gcount[k] = 0;
        for (int k = 0; k < n; k++) exp_q.push_back(ref_next(r));
        @(negedge clk);
        cur_tag = tag;
        req = r;
        do @(negedge clk); while (exp_q.size() != 0);
        req = '0;
        repeat (4) @(negedge clk);
    endtask

    // Monitor: compares each new grant with the scoreboard, then completes it
    initial begin
        int e, held;
        pkt_done = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && gnt_valid && !pkt_done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, {cur_tag, " unexpected grant"}, int'(gnt_idx), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(int'(gnt_idx) == e, cur_tag, int'(gnt_idx), e);
                end
                gcount[gnt_idx]++;
                held = int'(gnt_idx);
                for (int h = 0; h < hold_cycles; h++) begin
                    @(negedge clk);
                    check(gnt_valid && int'(gnt_idx) == held, "R8 hold", int'(gnt_idx), held);
                end
                pkt_done = 1'b1;
                @(negedge clk);
                pkt_done = 1'b0;
                check(!gnt_valid, "R8 release", int'(gnt_valid), 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NQ; i++) begin m_prio[i] = 0; m_tail[i] = 0; end
        rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_prio = '0; cfg_tail = 1'b0;
        req = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        // R1: nothing eligible after reset
        check(!gnt_valid, "R1 no grant after reset", int'(gnt_valid), 0);
        check(!cfg_err, "R1 error clear after reset", int'(cfg_err), 0);
        req = '0;
        repeat (3) @(negedge clk);

        // R2 R5 R6: weights over eight rounds, tail at queue 3
        cfg_write(0, 8, 0, "R2 cfg");
        cfg_write(1, 1, 0, "R2 cfg");
        cfg_write(2, 0, 0, "R2 cfg");
        cfg_write(3, 4, 1, "R6 cfg");
        cfg_write(5, 8, 0, "R6 cfg");
        run(8'hFF, 13, "R2 R5 order");
        check(gcount[0] == 8, "R2 code8 share", gcount[0], 8);
        check(gcount[1] == 1, "R2 code1 share", gcount[1], 1);
        check(gcount[2] == 0, "R2 code0 share", gcount[2], 0);
        check(gcount[3] == 4, "R2 code4 share", gcount[3], 4);
        check(gcount[5] == 0, "R6 beyond tail", gcount[5], 0);

        // R8: long hold before completion
        hold_cycles = 4;
        run(8'h01, 2, "R8 hold grant");
        hold_cycles = 0;

        // R3 R4: strict prefix group
        cfg_write(0, 9, 0, "R3 accept head");
        cfg_write(1, 9, 0, "R3 accept second");
        run(8'h0B, 3, "R4 lowest strict");
        run(8'h0A, 3, "R4 second strict");
        cfg_write(3, 9, 1, "R3 reject gap");
        run(8'h08, 2, "R3 gap queue unchanged");
        cfg_write(0, 1, 0, "R3 reject head clear");
        run(8'h03, 2, "R3 head still strict");

        // R7 R9: out-of-range code
        cfg_write(2, 13, 0, "R7 R9 bad code sticky");
        run(8'h0C, 6, "R7 full mask");

        // R10: live reprogramming back to weights
        cfg_write(1, 8, 0, "R10 cfg");
        cfg_write(0, 2, 0, "R10 cfg");
        run(8'h03, 6, "R10 new weights");
        check(gcount[1] == 5 || gcount[1] == 4 || gcount[1] == 6, "R10 q1 dominant", gcount[1], 5);

        // R6: removing the tail opens the upper queues
        cfg_write(3, 4, 0, "R6 cfg");
        run(8'h20, 2, "R6 no tail");
        check(gcount[5] == 2, "R6 upper queue served", gcount[5], 2);

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule